// File: doc/BRIEF.md
# Resumable NMI Trap Controller

This block sits next to a hart's trap logic. It handles resumable non-maskable interrupts and chooses the destination of every trap the hart takes. Sixteen level-sensitive request lines feed a pending register. While the enable bit in the shadow status register is set, a pending request outranks every ordinary interrupt. Taking one saves the hart's privilege level, its virtualization flag, its PC and the cause into a shadow register set. It then sends the hart to a fixed interrupt vector in machine mode. The ordinary trap registers of the hart are not touched.

Every trap decision, and every update to a register, is made on one clock edge. That edge produces a one-cycle `trap_taken` strobe together with the registered `next_pc` and `next_priv`. A synchronous exception always wins over an interrupt in the same cycle. If the exception is headed for machine mode while the enable bit is clear, the hart goes to a second fixed vector instead of the normal machine trap vector.

Ordinary traps follow the usual routing. A trap goes to supervisor mode when the hart runs at S or U, the cause is below 64 and the delegation bit for that cause is set. A machine or supervisor vector in mode 1 adds 4 × cause, but only for interrupts. Both fixed vectors are per-instance parameters and default to 0. A side-band `nmie_set` input stands in for the return instruction and sets the enable bit again.

Top module: `rnmi_trap_ctrl`

## Requirements
- R1: The pending register loads the request lines on every clock edge, so pending bit i equals request line i from the previous cycle.
- R2: While the enable bit (status bit 3) is 0, `intr_pend` stays low and neither a request line nor `irq_valid` causes a trap.
- R3: While the enable bit is 1 and no exception is valid, any set pending bit causes a resumable NMI entry ahead of `irq_valid`. The recorded cause index is the lowest set pending bit.
- R4: On entry, the enable bit is cleared and `cur_virt` is stored in status bit 7. `cur_priv` is stored in status bits 12:11. `mncause` becomes the cause index with bit XLEN-1 set, and `mnepc` takes `cur_pc`.
- R5: The edge of an entry raises `trap_taken` and sets `next_pc` to `IRQ_VEC` and `next_priv` to 3 (machine).
- R6: A synchronous exception routed to machine mode while the enable bit is 0 sets `next_pc` to `EXC_VEC`. The shadow status, cause and PC registers are left unchanged.
- R7: For other machine-mode traps, `next_pc` is `mtvec` with its two low bits cleared. For an interrupt with `mtvec[1:0]` equal to 1, 4 × cause is added. Exceptions never get the offset.
- R8: A trap that is not a resumable NMI goes to privilege 1 with the same vector rule applied to `stvec`, but only when `cur_priv` ≤ 1, the cause is below 64 and the matching bit of `ideleg` (interrupts) or `edeleg` (exceptions) is set. Otherwise it goes to privilege 3.
- R9: After reset, `mnstatus` is 0x8 (enable set), `mncause`, `mnepc`, `next_pc` and `trap_taken` are 0, and `next_priv` is 3.
- R10: An exception and a pending resumable NMI in the same cycle give the exception trap. The NMI entry follows on the next edge if the request is still pending.
- R11: `nmie_set` sets the enable bit on the next edge unless an entry happens on that edge. All other status fields keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_req | input | N_SRC (16) | Level-sensitive resumable NMI request lines |
| cur_pc | input | XLEN | PC of the instruction being interrupted |
| cur_priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| cur_virt | input | 1 | Current virtualization flag |
| exc_valid | input | 1 | A synchronous exception is raised this cycle |
| exc_cause | input | CAUSE_W (7) | Exception cause number |
| irq_valid | input | 1 | An enabled ordinary interrupt is requested |
| irq_cause | input | CAUSE_W (7) | Ordinary interrupt cause number |
| edeleg | input | 64 | Exception delegation bits |
| ideleg | input | 64 | Interrupt delegation bits |
| mtvec | input | XLEN | Machine trap vector (mode in bits 1:0) |
| stvec | input | XLEN | Supervisor trap vector (mode in bits 1:0) |
| nmie_set | input | 1 | Side-band request to set the enable bit again |
| trap_taken | output | 1 | One-cycle strobe for a trap taken on the last edge |
| next_pc | output | XLEN | Target PC of the last trap taken |
| next_priv | output | 2 | Target privilege of the last trap taken |
| intr_pend | output | 1 | Some interrupt would be taken this cycle |
| nmi_pend | output | N_SRC (16) | Pending register |
| mnstatus | output | XLEN | Shadow status register |
| mncause | output | XLEN | Shadow cause register |
| mnepc | output | XLEN | Shadow exception PC |

## Verification
Corrupted state in this block shows up at the ports within one cycle. A pending bit that disagrees with the request lines changes `nmi_pend` on the next edge. It also changes the recorded cause index, or whether an entry happens at all, on the edge after that. An enable bit stuck high lets traps through during the masked window, and one stuck low hides every interrupt and moves machine exceptions to the wrong vector. Both show up as a wrong `trap_taken` or `next_pc` on the first edge where the stimulus separates the two cases. A behavioural model in the bench therefore compares every output on every cycle, so a divergence is caught on the cycle it first appears.

// File: rtl/rnmi_pkg.sv
// Shared definitions for the resumable NMI trap controller.
// Assumes privilege encoding 0 = U, 1 = S, 3 = M.
package rnmi_pkg;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    // Fixed field positions inside the shadow status register
    localparam int ST_NMIE_BIT = 3;
    localparam int ST_PV_BIT   = 7;
    localparam int ST_PP_LO    = 11;

    // Number of causes covered by the delegation masks
    localparam int DELEG_W = 64;

    typedef enum logic [1:0] {
        TK_NONE = 2'd0,
        TK_EXC  = 2'd1,
        TK_RNMI = 2'd2,
        TK_IRQ  = 2'd3
    } take_e;
endpackage

// File: rtl/rnmi_pend_arb.sv
// Pending register plus lowest-index arbiter for the resumable NMI lines.
// Assumes the request lines are already synchronous to clk.
module rnmi_pend_arb #(
    parameter int N_SRC = 16,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req,
    output logic [N_SRC-1:0] pend,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Pending bits follow the request levels
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= req;
    end

    // Lowest set bit wins: scan downward so the last hit is the lowest
    always_comb begin
        idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend[i]) idx = IDX_W'(i);
        end
        any = |pend;
    end

    // R3
    lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (pend[idx] &&
                 ((pend & (({{(N_SRC-1){1'b0}}, 1'b1} << idx) - 1'b1)) == '0)));
endmodule

// File: rtl/rnmi_trap_vec.sv
// Vector address calculation for an ordinary trap vector register.
// Assumes mode 1 in the low two bits means vectored interrupts.
module rnmi_trap_vec #(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 7
) (
    input  logic [XLEN-1:0]    base,
    input  logic [CAUSE_W-1:0] cause,
    input  logic               is_async,
    output logic [XLEN-1:0]    pc
);
    logic [XLEN-1:0] offs;

    // Offset only for interrupts in vectored mode
    always_comb begin
        offs = (is_async && base[1:0] == 2'b01) ? (XLEN'(cause) << 2) : '0;
        pc   = {base[XLEN-1:2], 2'b00} + offs;
    end
endmodule

// File: rtl/rnmi_shadow_regs.sv
// Shadow status, cause and exception-PC registers for resumable NMIs.
// Assumes enter is only raised while the enable bit is set.
module rnmi_shadow_regs
    import rnmi_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enter,
    input  logic             nmie_set,
    input  logic [1:0]       cur_priv,
    input  logic             cur_virt,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic [IDX_W-1:0] idx,
    output logic             nmie,
    output logic [XLEN-1:0]  status,
    output logic [XLEN-1:0]  cause,
    output logic [XLEN-1:0]  epc
);
    logic       pv_q;
    logic [1:0] pp_q;

    // Entry saves the hart context; the side-band port re-enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmie  <= 1'b1;
            pv_q  <= 1'b0;
            pp_q  <= 2'b00;
            cause <= '0;
            epc   <= '0;
        end else if (enter) begin
            nmie  <= 1'b0;
            pv_q  <= cur_virt;
            pp_q  <= cur_priv;
            cause <= {1'b1, {(XLEN-1-IDX_W){1'b0}}, idx};
            epc   <= cur_pc;
        end else if (nmie_set) begin
            nmie  <= 1'b1;
        end
    end

    // Assemble the status word from its fields
    always_comb begin
        status = '0;
        status[ST_NMIE_BIT]          = nmie;
        status[ST_PV_BIT]            = pv_q;
        status[ST_PP_LO +: 2]        = pp_q;
    end

    // R4
    cause_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nmie) |-> cause[XLEN-1]);

    // R11
    reenable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(nmie_set) && !$past(enter)) |-> nmie);
endmodule

// File: rtl/rnmi_trap_ctrl.sv
// Trap controller: decides between exceptions, resumable NMIs and ordinary
// interrupts, routes them to a privilege and vector, and registers the result.
// Assumes irq_valid is already masked by the ordinary interrupt enables.
module rnmi_trap_ctrl
    import rnmi_pkg::*;
#(
    parameter int          XLEN    = 32,
    parameter int          N_SRC   = 16,
    parameter int          CAUSE_W = 7,
    parameter logic [63:0] IRQ_VEC = 64'h0,
    parameter logic [63:0] EXC_VEC = 64'h0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SRC-1:0]   nmi_req,
    input  logic [XLEN-1:0]    cur_pc,
    input  logic [1:0]         cur_priv,
    input  logic               cur_virt,
    input  logic               exc_valid,
    input  logic [CAUSE_W-1:0] exc_cause,
    input  logic               irq_valid,
    input  logic [CAUSE_W-1:0] irq_cause,
    input  logic [63:0]        edeleg,
    input  logic [63:0]        ideleg,
    input  logic [XLEN-1:0]    mtvec,
    input  logic [XLEN-1:0]    stvec,
    input  logic               nmie_set,
    output logic               trap_taken,
    output logic [XLEN-1:0]    next_pc,
    output logic [1:0]         next_priv,
    output logic               intr_pend,
    output logic [N_SRC-1:0]   nmi_pend,
    output logic [XLEN-1:0]    mnstatus,
    output logic [XLEN-1:0]    mncause,
    output logic [XLEN-1:0]    mnepc
);
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
    localparam logic [XLEN-1:0] IRQ_PC = IRQ_VEC[XLEN-1:0];
    localparam logic [XLEN-1:0] EXC_PC = EXC_VEC[XLEN-1:0];

    logic               pend_any;
    logic [IDX_W-1:0]   pend_idx;
    logic               nmie;
    take_e              kind;
    logic [CAUSE_W-1:0] t_cause;
    logic               t_async;
    logic               to_s;
    logic [XLEN-1:0]    m_pc, s_pc, pc_d;
    logic [63:0]        dmask;

    rnmi_pend_arb #(.N_SRC(N_SRC)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(nmi_req),
        .pend(nmi_pend), .any(pend_any), .idx(pend_idx)
    );

    rnmi_shadow_regs #(.XLEN(XLEN), .IDX_W(IDX_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .enter(kind == TK_RNMI),
        .nmie_set(nmie_set), .cur_priv(cur_priv), .cur_virt(cur_virt),
        .cur_pc(cur_pc), .idx(pend_idx), .nmie(nmie),
        .status(mnstatus), .cause(mncause), .epc(mnepc)
    );

    rnmi_trap_vec #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_mvec (
        .base(mtvec), .cause(t_cause), .is_async(t_async), .pc(m_pc)
    );

    rnmi_trap_vec #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_svec (
        .base(stvec), .cause(t_cause), .is_async(t_async), .pc(s_pc)
    );

    // Pick the trap kind: exception, then resumable NMI, then ordinary
    always_comb begin
        if (exc_valid)               kind = TK_EXC;
        else if (nmie && pend_any)   kind = TK_RNMI;
        else if (nmie && irq_valid)  kind = TK_IRQ;
        else                         kind = TK_NONE;
        intr_pend = nmie && (pend_any || irq_valid);
    end

    // Route to a privilege and compute the target PC
    always_comb begin
        t_async = (kind == TK_IRQ);
        t_cause = exc_valid ? exc_cause : irq_cause;
        dmask   = t_async ? ideleg : edeleg;
        to_s    = (kind == TK_EXC || kind == TK_IRQ) && (cur_priv <= PRIV_S) &&
                  ((t_cause >> 6) == '0) && dmask[t_cause[5:0]];
        if (kind == TK_RNMI)              pc_d = IRQ_PC;
        else if (to_s)                    pc_d = s_pc;
        else if (kind == TK_EXC && !nmie) pc_d = EXC_PC;
        else                              pc_d = m_pc;
    end

    // Register the trap outcome on the decision edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_taken <= 1'b0;
            next_pc    <= '0;
            next_priv  <= PRIV_M;
        end else begin
            trap_taken <= (kind != TK_NONE);
            if (kind != TK_NONE) begin
                next_pc   <= pc_d;
                next_priv <= to_s ? PRIV_S : PRIV_M;
            end
        end
    end

    // R2
    masked_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_taken && !$past(nmie)) |-> $past(exc_valid));

    // R5
    entry_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nmie) |-> (trap_taken && next_pc == IRQ_PC && next_priv == PRIV_M));

    // R6
    masked_exc_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_taken && $past(exc_valid) && !$past(nmie) && next_priv == PRIV_M)
            |-> next_pc == EXC_PC);
endmodule

// File: tb/rnmi_trap_ctrl_tb.sv
// Bench: directed scenarios plus a random phase, with a behavioural
// reference model compared against every output each clock.
module rnmi_trap_ctrl_tb;
    localparam int CLK_P = 10;
    localparam logic [31:0] IVEC = 32'h0000_0100;
    localparam logic [31:0] EVEC = 32'h0000_0200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] nmi_req = '0;
    logic [31:0] cur_pc = '0;
    logic [1:0]  cur_priv = 2'd3;
    logic        cur_virt = 1'b0;
    logic        exc_valid = 1'b0;
    logic [6:0]  exc_cause = '0;
    logic        irq_valid = 1'b0;
    logic [6:0]  irq_cause = '0;
    logic [63:0] edeleg = '0;
    logic [63:0] ideleg = '0;
    logic [31:0] mtvec = 32'h0000_1000;
    logic [31:0] stvec = 32'h0000_2000;
    logic        nmie_set = 1'b0;

    logic        trap_taken, intr_pend;
    logic [31:0] next_pc, mnstatus, mncause, mnepc;
    logic [1:0]  next_priv;
    logic [15:0] nmi_pend;

    rnmi_trap_ctrl #(.XLEN(32), .N_SRC(16), .CAUSE_W(7),
                     .IRQ_VEC(64'(IVEC)), .EXC_VEC(64'(EVEC))) u_dut (
        .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .cur_pc(cur_pc),
        .cur_priv(cur_priv), .cur_virt(cur_virt), .exc_valid(exc_valid),
        .exc_cause(exc_cause), .irq_valid(irq_valid), .irq_cause(irq_cause),
        .edeleg(edeleg), .ideleg(ideleg), .mtvec(mtvec), .stvec(stvec),
        .nmie_set(nmie_set), .trap_taken(trap_taken), .next_pc(next_pc),
        .next_priv(next_priv), .intr_pend(intr_pend), .nmi_pend(nmi_pend),
        .mnstatus(mnstatus), .mncause(mncause), .mnepc(mnepc)
    );

    always #(CLK_P/2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit started = 1'b0;
    bit done = 1'b0;

    // Reference model state
    logic [15:0] m_pend;
    bit          m_nmie, m_pv, m_taken;
    logic [1:0]  m_pp, m_priv;
    logic [31:0] m_cause, m_epc, m_pc;

    function automatic logic [31:0] vec_of(logic [31:0] base, int cause, bit asy);
        logic [31:0] r;
        r = base & ~32'h3;
        if (asy && base[1:0] == 2'b01) r = r + 32'(cause * 4);
        return r;
    endfunction

    task automatic cmp(string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: one decision per rising edge
    always @(posedge clk) begin
        started = 1'b1;
        if (!rst_n) begin
            m_pend = '0; m_nmie = 1; m_pv = 0; m_pp = 0; m_cause = 0; m_epc = 0;
            m_taken = 0; m_pc = 0; m_priv = 3;
        end else begin
            int c; bit asy, sdel; logic [63:0] dm; int low;
            bit rnmi;
            low = -1;
            for (int i = 0; i < 16; i++) if (m_pend[i] && low < 0) low = i;
            rnmi = 0; m_taken = 0;
            if (exc_valid) begin
                m_taken = 1; asy = 0; c = int'(exc_cause);
            end else if (m_nmie && low >= 0) begin
                m_taken = 1; rnmi = 1; asy = 0; c = low;
            end else if (m_nmie && irq_valid) begin
                m_taken = 1; asy = 1; c = int'(irq_cause);
            end else begin
                asy = 0; c = 0;
            end
            if (rnmi) begin
                m_pv = cur_virt; m_pp = cur_priv; m_epc = cur_pc;
                m_cause = 32'h8000_0000 | 32'(c);
                m_pc = IVEC; m_priv = 3;
            end else if (m_taken) begin
                dm = asy ? ideleg : edeleg;
                sdel = (cur_priv <= 1) && (c < 64) && dm[c % 64];
                if (sdel) begin
                    m_pc = vec_of(stvec, c, asy); m_priv = 1;
                end else begin
                    m_priv = 3;
                    m_pc = (!asy && !m_nmie) ? EVEC : vec_of(mtvec, c, asy);
                end
            end
            if (rnmi) m_nmie = 0;
            else if (nmie_set) m_nmie = 1;
            m_pend = nmi_req;
        end
    end

    // Compare all outputs a quarter period after each rising edge
    always @(posedge clk) begin
        #(CLK_P/4);
        if (started && !done) begin
            cmp("R1 pending", 64'(nmi_pend), 64'(m_pend));
            cmp("R4 R11 status", 64'(mnstatus),
                64'((32'(m_nmie) << 3) | (32'(m_pv) << 7) | (32'(m_pp) << 11)));
            cmp("R3 R4 cause", 64'(mncause), 64'(m_cause));
            cmp("R4 epc", 64'(mnepc), 64'(m_epc));
            cmp("R2 R10 taken", 64'(trap_taken), 64'(m_taken));
            cmp("R5 R6 R7 pc", 64'(next_pc), 64'(m_pc));
            cmp("R8 priv", 64'(next_priv), 64'(m_priv));
            cmp("R2 intr_pend", 64'(intr_pend),
                64'(m_nmie && (m_pend != 0 || irq_valid)));
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) tick();
        // R9 reset values
        cmp("R9 status", 64'(mnstatus), 64'h8);
        cmp("R9 cause", 64'(mncause), 64'h0);
        cmp("R9 pc", 64'(next_pc), 64'h0);
        cmp("R9 priv", 64'(next_priv), 64'h3);
        cmp("R9 taken", 64'(trap_taken), 64'h0);
        rst_n = 1'b1;
        nmi_req = 16'h0028; cur_pc = 32'h1234; cur_priv = 0; cur_virt = 1;
        tick();
        cmp("R1 captured", 64'(nmi_pend), 64'h28);
        cmp("R3 no trap yet", 64'(trap_taken), 64'h0);
        tick();
        cmp("R3 lowest cause", 64'(mncause), 64'h8000_0003);
        cmp("R4 saved status", 64'(mnstatus), 64'h80);
        cmp("R4 saved epc", 64'(mnepc), 64'h1234);
        cmp("R5 vector", 64'(next_pc), 64'(IVEC));
        cmp("R5 priv", 64'(next_priv), 64'h3);
        // Masked window: requests and interrupts must be ignored
        cur_priv = 3; cur_virt = 0; irq_valid = 1; irq_cause = 5;
        for (int k = 0; k < 3; k++) begin
            tick();
            cmp("R2 no trap while masked", 64'(trap_taken), 64'h0);
            cmp("R2 intr_pend masked", 64'(intr_pend), 64'h0);
        end
        exc_valid = 1; exc_cause = 2;
        tick();
        cmp("R6 exc vector", 64'(next_pc), 64'(EVEC));
        cmp("R6 cause kept", 64'(mncause), 64'h8000_0003);
        exc_valid = 0; irq_valid = 0; nmi_req = 0; nmie_set = 1;
        tick();
        cmp("R11 enable restored", 64'(mnstatus), 64'h88);
        nmie_set = 0; irq_valid = 1; irq_cause = 5; mtvec = 32'h1001;
        tick();
        cmp("R7 vectored irq", 64'(next_pc), 64'h1014);
        cur_priv = 0; ideleg = 64'h20; stvec = 32'h2001;
        tick();
        cmp("R8 delegated irq pc", 64'(next_pc), 64'h2014);
        cmp("R8 delegated irq priv", 64'(next_priv), 64'h1);
        irq_valid = 0; exc_valid = 1; exc_cause = 70; edeleg = '1;
        tick();
        cmp("R8 cause above 63", 64'(next_priv), 64'h3);
        cmp("R7 exc no offset", 64'(next_pc), 64'h1000);
        exc_cause = 13; cur_priv = 1;
        tick();
        cmp("R8 exc to S", 64'(next_pc), 64'h2000);
        cur_priv = 3;
        tick();
        cmp("R8 exc from M", 64'(next_priv), 64'h3);
        exc_valid = 0; nmi_req = 16'h1200;
        tick();
        exc_valid = 1; exc_cause = 4;
        tick();
        cmp("R10 exception first", 64'(next_pc), 64'h1000);
        cmp("R10 enable held", 64'(mnstatus), 64'h88);
        exc_valid = 0; cur_pc = 32'h5000;
        tick();
        cmp("R10 entry next", 64'(mncause), 64'h8000_0009);
        cmp("R10 epc", 64'(mnepc), 64'h5000);
        // Random phase
        for (int k = 0; k < 600; k++) begin
            logic [1:0] p;
            nmi_req   = ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'h0;
            irq_valid = $urandom_range(0, 1) == 1;
            irq_cause = 7'($urandom);
            exc_valid = $urandom_range(0, 5) == 0;
            exc_cause = 7'($urandom);
            nmie_set  = $urandom_range(0, 7) == 0;
            p = 2'($urandom_range(0, 2));
            cur_priv  = (p == 2) ? 2'd3 : p;
            cur_virt  = $urandom_range(0, 1) == 1;
            cur_pc    = $urandom;
            mtvec     = {24'h0000_30, 6'($urandom), 2'($urandom)};
            stvec     = {24'h0000_40, 6'($urandom), 2'($urandom)};
            edeleg    = {$urandom, $urandom};
            ideleg    = {$urandom, $urandom};
            tick();
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule